// File: doc/BRIEF.md
# Peripheral Interrupt Collector with Per-Line Polarity

This block gathers a group of slow peripheral interrupt request lines, up to eighteen, and presents them to a parent interrupt controller as one active-high summary line. Every request passes through a two-flop synchronizer and a polarity correction before it is latched into a sticky status bit. Software picks level or edge capture for the whole group, unmasks lines one at a time and acknowledges them by writing ones to a clear register.

The register port is a plain single-cycle bus. Writes take effect on the rising clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the registered state while `bus_sel` is high and `bus_wr` is low. The summary output rises when the global enable is set and at least one status bit is set whose enable bit is also set.

Top module: `irq_gather`

## Requirements
- R1: After reset the control, enable, status and polarity registers read zero and `irq_out` is low. While the inputs are held inactive for the reset polarity (all ones), status stays zero after reset is released.
- R2: Word offsets are control 0x00, enable 0x04, status 0x08, clear 0x0C and polarity 0x10.
  - Control keeps only bit 31 (global enable) and bit 30 (edge mode); all its other bits read zero.
  - Bits 31 down to 18 of the enable, status and polarity registers read zero.
  - The clear register and every undecoded offset read zero.
- R3: An enable bit of 1 unmasks its line and an enable bit of 0 masks it. `irq_out` is high exactly when the global enable is set and the bitwise AND of enable and status is nonzero.
- R4: While control bit 31 is 0, `irq_out` stays low whatever the status and enable bits hold.
- R5: A polarity bit of 1 makes its request active high. A polarity bit of 0 makes it active low.
- R6: In level mode (control bit 30 = 0), a status bit is set on every clock edge while its corrected input is active. A clear written while the input is still active does not leave the bit cleared. Once set, the bit stays set after the input is released, until a clear is written.
- R7: In edge mode (control bit 30 = 1), a status bit sets only on a low-to-high transition of its corrected input and holds until cleared. Holding the input active does not set the bit again after a clear. Writing a 0 to a bit of the clear register leaves that status bit unchanged.
- R8: When a capture and a clear of the same status bit fall on the same clock edge, the bit ends up set.
- R9: A request input change that arrives before clock edge E1 is first visible in the status register after the third rising edge (E3), not after the second.
- R10: Writes to the status register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | NUM_SRC (18) | Asynchronous interrupt request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address; bits 1:0 are ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data; zero when no read is selected |
| irq_out | output | 1 | Level-high summary to the parent controller |

## Verification
The hardest case to reach from the ports is a clear write landing on the very edge where an edge-mode capture fires. The capture edge sits behind two synchronizer flops and an edge detector, so its cycle is fixed only by counting from the moment the request line changes. The bench raises a request on a falling clock edge and counts exactly two more falling edges. It then issues the clear so that the write commits on the third rising edge, the same edge as the capture. The same counted timing is used to confirm that status is still zero after the second edge and set after the third.

// File: rtl/irq_gather_pkg.sv
// Package: shared constants for the interrupt collector.
// Assumes word-aligned register offsets; the register index is the byte
// address shifted right by two.
package irq_gather_pkg;

    // Word indices of the five decoded registers
    localparam int IDX_CTL = 0;
    localparam int IDX_ENA = 1;
    localparam int IDX_STS = 2;
    localparam int IDX_CLR = 3;
    localparam int IDX_POL = 4;

    // Capture style selected by the control word
    typedef enum logic {
        CAP_LEVEL = 1'b0,
        CAP_EDGE  = 1'b1
    } cap_mode_e;

endpackage

// File: rtl/irq_gather_sync.sv
// Module: irq_gather_sync
// Two-flop synchronizer for every request line, plus a fill qualifier.
// The qualifier stays low until both stages hold sampled data after reset.
// Assumes the request inputs are asynchronous and held for at least
// two clock cycles.
module irq_gather_sync #(
    parameter int N = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] sync_out,
    output logic         fill_ok
);

    localparam int STAGES = 2;

    logic [STAGES-1:0] fill_sr;

    // Shift ones in after reset so that downstream logic ignores reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sr <= '0;
        end else begin
            fill_sr <= {fill_sr[STAGES-2:0], 1'b1};
        end
    end

    assign fill_ok = fill_sr[STAGES-1];

    for (genvar g = 0; g < N; g++) begin : g_line
        logic stage_a;
        logic stage_b;

        // Two-stage metastability filter for one request line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_a <= 1'b0;
                stage_b <= 1'b0;
            end else begin
                stage_a <= raw_in[g];
                stage_b <= stage_a;
            end
        end

        assign sync_out[g] = stage_b;
    end

endmodule

// File: rtl/irq_gather_capture.sv
// Module: irq_gather_capture
// Per-line polarity correction, edge detection and sticky status bits.
// Assumes synchronized inputs. When a set and a clear hit one bit on the
// same edge, the set wins.
module irq_gather_capture #(
    parameter int N = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              sync_in,
    input  logic                      fill_ok,
    input  logic [N-1:0]              pol_hi,
    input  irq_gather_pkg::cap_mode_e mode,
    input  logic [N-1:0]              clr_mask,
    output logic [N-1:0]              active,
    output logic [N-1:0]              status
);

    import irq_gather_pkg::*;

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_q;
        logic rise;
        logic set_now;
        logic sts_q;

        // Active after the polarity correction; held low until the synchronizer has filled
        assign active[g] = fill_ok & ~(sync_in[g] ^ pol_hi[g]);
        assign rise      = active[g] & ~prev_q;
        assign set_now   = (mode == CAP_EDGE) ? rise : active[g];

        // Remember the previous corrected level for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
            end else begin
                prev_q <= active[g];
            end
        end

        // Sticky status bit: a capture overrides a clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q <= 1'b0;
            end else begin
                sts_q <= (sts_q & ~clr_mask[g]) | set_now;
            end
        end

        assign status[g] = sts_q;
    end

endmodule

// File: rtl/irq_gather_regs.sv
// Module: irq_gather_regs
// Register file and address decode for the collector.
// Assumes a single-cycle bus: writes commit on the clock edge where the
// strobe is high; reads are combinational. Unused bits and undecoded
// offsets read zero.
module irq_gather_regs #(
    parameter int N      = 18,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [N-1:0]              status,
    output logic [N-1:0]              ena,
    output logic [N-1:0]              pol_hi,
    output logic                      gen_en,
    output irq_gather_pkg::cap_mode_e mode,
    output logic [N-1:0]              clr_mask
);

    import irq_gather_pkg::*;

    localparam int IDX_W   = ADDR_W - 2;
    localparam int GEN_BIT = DATA_W - 1;
    localparam int EDG_BIT = DATA_W - 2;
    localparam int PAD_W   = DATA_W - N;

    logic [IDX_W-1:0] idx;
    logic             wr_go;
    logic             rd_go;
    logic             hit_ctl;
    logic             hit_ena;
    logic             hit_sts;
    logic             hit_clr;
    logic             hit_pol;

    assign idx   = bus_addr[ADDR_W-1:2];
    assign wr_go = bus_sel & bus_wr;
    assign rd_go = bus_sel & ~bus_wr;

    // Decode the word index into one hit per register
    always_comb begin
        hit_ctl = (idx == IDX_W'(IDX_CTL));
        hit_ena = (idx == IDX_W'(IDX_ENA));
        hit_sts = (idx == IDX_W'(IDX_STS));
        hit_clr = (idx == IDX_W'(IDX_CLR));
        hit_pol = (idx == IDX_W'(IDX_POL));
    end

    // Control word: global enable and capture mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= 1'b0;
            mode   <= CAP_LEVEL;
        end else if (wr_go && hit_ctl) begin
            gen_en <= bus_wdata[GEN_BIT];
            mode   <= cap_mode_e'(bus_wdata[EDG_BIT]);
        end
    end

    // Per-line enable mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena <= '0;
        end else if (wr_go && hit_ena) begin
            ena <= bus_wdata[N-1:0];
        end
    end

    // Per-line polarity selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_hi <= '0;
        end else if (wr_go && hit_pol) begin
            pol_hi <= bus_wdata[N-1:0];
        end
    end

    // Write-one-to-clear pulse towards the status bits
    assign clr_mask = (wr_go && hit_clr) ? bus_wdata[N-1:0] : '0;

    // Read multiplexer; clear, status-write and undecoded offsets give zero
    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            if (hit_ctl) begin
                bus_rdata[GEN_BIT] = gen_en;
                bus_rdata[EDG_BIT] = (mode == CAP_EDGE);
            end else if (hit_ena) begin
                bus_rdata = {{PAD_W{1'b0}}, ena};
            end else if (hit_sts) begin
                bus_rdata = {{PAD_W{1'b0}}, status};
            end else if (hit_pol) begin
                bus_rdata = {{PAD_W{1'b0}}, pol_hi};
            end
        end
    end

    // hit_sts is intentionally unused on writes: status is read-only
    logic unused_ok;
    assign unused_ok = &{1'b0, bus_addr[1:0]};

endmodule

// File: rtl/irq_gather.sv
// Module: irq_gather (top)
// Collects NUM_SRC request lines into sticky status bits and drives one
// level-high summary line when the global enable is set and any enabled
// status bit is set.
// Assumes NUM_SRC <= DATA_W - 2, so that the sources stay clear of the
// control bits.
module irq_gather #(
    parameter int NUM_SRC = 18,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    import irq_gather_pkg::*;

    logic [NUM_SRC-1:0] req_sync;
    logic               fill_ok;
    logic [NUM_SRC-1:0] act_vec;
    logic [NUM_SRC-1:0] sts_vec;
    logic [NUM_SRC-1:0] ena_vec;
    logic [NUM_SRC-1:0] pol_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic               gen_en;
    cap_mode_e          cap_mode;

    irq_gather_sync #(.N(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (req_in),
        .sync_out (req_sync),
        .fill_ok  (fill_ok)
    );

    irq_gather_capture #(.N(NUM_SRC)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (req_sync),
        .fill_ok  (fill_ok),
        .pol_hi   (pol_vec),
        .mode     (cap_mode),
        .clr_mask (clr_vec),
        .active   (act_vec),
        .status   (sts_vec)
    );

    irq_gather_regs #(.N(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status    (sts_vec),
        .ena       (ena_vec),
        .pol_hi    (pol_vec),
        .gen_en    (gen_en),
        .mode      (cap_mode),
        .clr_mask  (clr_vec)
    );

    // Summary: any unmasked pending line while the group is enabled
    assign irq_out = gen_en & (|(ena_vec & sts_vec));

endmodule

// File: rtl/irq_gather_chk.sv
// Module: irq_gather_chk
// Property checker for irq_gather. It is attached to the top module by
// the bind statement at the end of this file and observes the top's
// internal nets.
module irq_gather_chk #(
    parameter int N  = 18,
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gen_en,
    input logic          edge_mode,
    input logic [N-1:0]  ena,
    input logic [N-1:0]  status,
    input logic [N-1:0]  active,
    input logic [N-1:0]  clr_mask,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          irq_out
);

    // R4
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |-> !irq_out);

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ena & status) == '0) |-> !irq_out);

    // R3
    pending_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && ((ena & status) != '0)) |-> irq_out);

    // R6
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && (active != '0)) |=> ((status & $past(active)) == $past(active)));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((status & $past(status)) == $past(status)));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr[AW-1:2] != '0)) |-> (bus_rdata[DW-1:N] == '0));

endmodule

bind irq_gather irq_gather_chk #(.N(NUM_SRC), .DW(DATA_W), .AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .edge_mode (cap_mode == irq_gather_pkg::CAP_EDGE),
    .ena       (ena_vec),
    .status    (sts_vec),
    .active    (act_vec),
    .clr_mask  (clr_vec),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
);

// File: tb/sim_irq_gather.sv
module sim_irq_gather;

    localparam int N  = 18;
    localparam int DW = 32;
    localparam int AW = 5;

    localparam logic [AW-1:0] A_CTL = 5'h00;
    localparam logic [AW-1:0] A_ENA = 5'h04;
    localparam logic [AW-1:0] A_STS = 5'h08;
    localparam logic [AW-1:0] A_CLR = 5'h0C;
    localparam logic [AW-1:0] A_POL = 5'h10;

    localparam logic [N-1:0] ALL = 18'h3FFFF;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req_in;
    logic          bus_sel;
    logic          bus_wr;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_gather u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Vector: control bits {enable, edge}, polarity, enable, request, expected status, expected summary
    typedef struct packed {
        logic [1:0]   ctl;
        logic [N-1:0] pol;
        logic [N-1:0] ena;
        logic [N-1:0] req;
        logic [N-1:0] st;
        logic         irq;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 18'h3FFFF, 18'h3FFFF, 18'h00001, 18'h00001, 1'b1},
        '{2'b10, 18'h3FFFF, 18'h00002, 18'h00001, 18'h00001, 1'b0},
        '{2'b00, 18'h3FFFF, 18'h3FFFF, 18'h20000, 18'h20000, 1'b0},
        '{2'b10, 18'h00000, 18'h3FFFF, 18'h3FFFE, 18'h00001, 1'b1},
        '{2'b11, 18'h3FFFF, 18'h30000, 18'h30005, 18'h30005, 1'b1},
        '{2'b10, 18'h0F0F0, 18'h00F00, 18'h00F0F, 18'h30000, 1'b0},
        '{2'b11, 18'h00000, 18'h3FFFF, 18'h3FF00, 18'h000FF, 1'b1}
    };

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called on a falling edge; the write commits on the next rising edge
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel  = 1'b0;
    endtask

    task automatic check_reg(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        bus_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic check_irq(input string tag, input logic exp);
        #1;
        check(tag, {31'b0, irq_out}, {31'b0, exp});
    endtask

    // Watchdog: a hung run is counted as a miscompare
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_in    = ALL;
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(4);

        // R1 reset state with inputs inactive for the reset polarity
        check_reg("R1 ctl", A_CTL, 32'h0);
        check_reg("R1 ena", A_ENA, 32'h0);
        check_reg("R1 sts", A_STS, 32'h0);
        check_reg("R1 pol", A_POL, 32'h0);
        check_irq("R1 irq", 1'b0);

        // Vector table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            req_in = ~VECS[i].pol;
            bus_write(A_CTL, 32'h0);
            bus_write(A_POL, {14'b0, VECS[i].pol});
            wait_cyc(4);
            bus_write(A_CLR, {14'b0, ALL});
            bus_write(A_ENA, {14'b0, VECS[i].ena});
            bus_write(A_CTL, {VECS[i].ctl, 30'b0});
            req_in = VECS[i].req;
            wait_cyc(4);
            check_reg($sformatf("R5/R6/R7 vec%0d status", i), A_STS, {14'b0, VECS[i].st});
            check_irq($sformatf("R3/R4 vec%0d irq", i), VECS[i].irq);
        end

        // R2 register map, unused bits and undecoded offsets
        bus_write(A_CTL, 32'h0);
        bus_write(A_ENA, 32'hFFFF_FFFF);
        check_reg("R2 ena upper bits", A_ENA, 32'h0003_FFFF);
        bus_write(A_ENA, 32'h0);
        bus_write(A_CTL, 32'hFFFF_FFFF);
        check_reg("R2 ctl bits", A_CTL, 32'hC000_0000);
        bus_write(A_CTL, 32'h0);
        check_reg("R2 clr reads zero", A_CLR, 32'h0);
        check_reg("R2 undecoded 0x14", 5'h14, 32'h0);
        check_reg("R2 undecoded 0x1C", 5'h1C, 32'h0);

        // Setup for the directed tests: active-high lines, all idle
        req_in = '0;
        bus_write(A_POL, {14'b0, ALL});
        wait_cyc(4);
        bus_write(A_CLR, {14'b0, ALL});
        check_reg("R6 setup clear", A_STS, 32'h0);

        // R10 status register writes are ignored
        bus_write(A_STS, 32'hFFFF_FFFF);
        check_reg("R10 status write ignored", A_STS, 32'h0);

        // R9 latency in level mode
        bus_write(A_CTL, 32'h8000_0000);
        bus_write(A_ENA, 32'h1);
        req_in[0] = 1'b1;
        wait_cyc(2);
        check_reg("R9 not after second edge", A_STS, 32'h0);
        wait_cyc(1);
        check_reg("R9 set after third edge", A_STS, 32'h1);
        check_irq("R9 irq", 1'b1);

        // R6 a clear while asserted does not stick; sticky after release
        bus_write(A_CLR, 32'h1);
        check_reg("R6 clear while asserted", A_STS, 32'h1);
        req_in[0] = 1'b0;
        wait_cyc(4);
        check_reg("R6 sticky after release", A_STS, 32'h1);
        bus_write(A_CLR, 32'h1);
        check_reg("R6 clear after release", A_STS, 32'h0);
        check_irq("R6 irq drops", 1'b0);

        // R7 edge mode: capture, hold, zero-write, no re-set while held
        bus_write(A_CTL, 32'hC000_0000);
        bus_write(A_ENA, 32'h8);
        req_in[3] = 1'b1;
        wait_cyc(4);
        req_in[3] = 1'b0;
        wait_cyc(4);
        check_reg("R7 edge capture held", A_STS, 32'h8);
        check_irq("R7 irq", 1'b1);
        bus_write(A_CLR, 32'h1);
        check_reg("R7 zero bit leaves status", A_STS, 32'h8);
        bus_write(A_CLR, 32'h8);
        check_reg("R7 cleared", A_STS, 32'h0);
        req_in[3] = 1'b1;
        wait_cyc(4);
        bus_write(A_CLR, 32'h8);
        wait_cyc(2);
        check_reg("R7 no re-set while held", A_STS, 32'h0);
        req_in[3] = 1'b0;
        wait_cyc(4);

        // R8 capture and clear on the same edge: capture wins
        req_in[5] = 1'b1;
        wait_cyc(2);
        bus_write(A_CLR, 32'h20);
        check_reg("R8 set wins", A_STS, 32'h20);
        bus_write(A_CLR, 32'h20);
        check_reg("R8 later clear", A_STS, 32'h0);
        req_in[5] = 1'b0;
        wait_cyc(4);

        // R5 polarity flip makes an idle-low line active; R4 gating
        bus_write(A_CTL, 32'h0);
        bus_write(A_ENA, 32'h80);
        bus_write(A_POL, {14'b0, ALL & ~18'h80});
        wait_cyc(4);
        check_reg("R5 active-low line captured", A_STS, 32'h80);
        check_irq("R4 gated off", 1'b0);
        bus_write(A_CTL, 32'h8000_0000);
        check_irq("R4 gated on", 1'b1);
        bus_write(A_POL, {14'b0, ALL});
        wait_cyc(4);
        bus_write(A_CLR, 32'h80);
        check_reg("R5 restored polarity", A_STS, 32'h0);
        check_irq("R3 irq after clear", 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule